// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

A small up counter whose state changes only on the rising clock edge. On each edge it takes exactly one action, chosen by fixed priority. An active-low clear forces zero. Otherwise an active-low load strobe copies a parallel data word. Otherwise the counter advances by one when both count enables are high. In every other case it keeps its value.

The two enables are not equivalent. Only the carry-gate enable is fed forward into the terminal-count flag, and the hold enable has no effect on that flag. This lets a chain of stages share one clock and one global count enable. Each stage's terminal count drives the carry-gate enable of the stage above it, so the chain counts as one wide counter without any ripple between stages. A maximum count below the natural wrap is built outside the block: decode the wanted final state and feed the result to the clear input.

An active-low reset, `rst_ni`, zeroes the count for power-up initialisation only. All functional actions are synchronous.

Top module: `presettable_counter`

## Requirements
- R1: When `clr_ni` is 0 at a rising edge, `count_o` is 0 after that edge, whatever `load_ni`, `en_p_i` and `en_t_i` are.
- R2: When `clr_ni` is 1 and `load_ni` is 0 at a rising edge, `count_o` equals the `data_i` sampled at that edge, whatever the two enables are.
- R3: When `clr_ni`, `load_ni`, `en_p_i` and `en_t_i` are all 1 at a rising edge, `count_o` increases by one modulo 2^WIDTH, so the all-ones value wraps to 0.
- R4: When `clr_ni` and `load_ni` are 1 and either enable is 0 at a rising edge, `count_o` keeps its value.
- R5: `tc_o` is 1 exactly when `count_o` is all ones and `en_t_i` is 1, within the same cycle; `en_p_i` does not affect it.
- R6: While `rst_ni` is 0, `count_o` is 0, without waiting for a clock edge.
- R7: Three stages can be chained, each stage's `tc_o` driving the next stage's `en_t_i`, with a shared clock, clear, load and `en_p_i`. The chain then behaves as a single 12-bit counter, including when load or clear is applied in the middle of a count.
- R8: Driving `clr_ni` low whenever `count_o` equals N-1 gives a modulo-N sequence 0, 1, …, N-1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| clr_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_ni | input | 1 | Synchronous parallel load strobe, active low |
| data_i | input | WIDTH | Value loaded by the load strobe |
| en_p_i | input | 1 | Hold enable; counting needs it high |
| en_t_i | input | 1 | Carry-gate enable; counting needs it high, and it gates `tc_o` |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count: all ones and `en_t_i` high |

## Verification
A single stage is checked against a reference integer on every cycle. The stimulus includes clear asserted together with load and both enables, which separates clear priority from load priority. Load is applied with both enables low, which shows that loading ignores the enables. Each enable is dropped alone at the all-ones state, which separates the hold path from the terminal-count gate. A three-stage chain runs across the 0xFF and 0xFFF carry boundaries, with loads and a clear in mid-sequence, which exposes any carry that leaks or lags by a cycle. A stage whose clear is driven from a decode of 9 must repeat a ten-state cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)                op_o = OP_CLEAR;
    else if (!load_ni)          op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_INC;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_reg.sv
module cnt_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH:0]   carry;

  // look-ahead carry: bit k toggles when all lower bits are ones
  assign carry[0] = 1'b1;
  for (genvar k = 0; k < WIDTH; k++) begin : g_carry
    assign carry[k+1] = carry[k] & q_q[k];
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_q[k] <= 1'b0;
      end else begin
        unique case (op_i)
          OP_CLEAR: q_q[k] <= 1'b0;
          OP_LOAD:  q_q[k] <= data_i[k];
          OP_INC:   q_q[k] <= q_q[k] ^ carry[k];
          default:  q_q[k] <= q_q[k];
        endcase
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             en_t_i,
  output logic             tc_o
);
  assign tc_o = en_t_i & (&q_i);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  cnt_op_e op;

  cnt_ctrl u_ctrl (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .op_o    (op)
  );

  cnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (data_i),
    .q_o    (count_o)
  );

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .q_i    (count_o),
    .en_t_i (en_t_i),
    .tc_o   (tc_o)
  );
endmodule

// File: rtl/presettable_counter_checks.sv
module presettable_counter_checks #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic [WIDTH-1:0] data_i,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o
);
  logic [WIDTH-1:0] inc_val;
  assign inc_val = count_o + 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0); // R1
  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> count_o == $past(data_i)); // R2
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && en_p_i && en_t_i |=> count_o == $past(inc_val)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !(en_p_i && en_t_i) |=> $stable(count_o)); // R4
  AST_TC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> en_t_i && (&count_o)); // R5
  AST_TC_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_t_i && (&count_o) |-> tc_o); // R5
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0); // R6
endmodule

bind presettable_counter presettable_counter_checks #(.WIDTH(WIDTH)) u_checks (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_ni  (clr_ni),
  .load_ni (load_ni),
  .data_i  (data_i),
  .en_p_i  (en_p_i),
  .en_t_i  (en_t_i),
  .count_o (count_o),
  .tc_o    (tc_o)
);

// File: tb/presettable_counter_test.sv
`timescale 1ns/1ps
module presettable_counter_test;
  localparam int MODN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // single stage
  logic       clr_n = 1'b1, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] d = 4'd0;
  logic [3:0] q;
  logic       tc;
  int         ref_q = 0;

  presettable_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(ld_n), .data_i(d),
    .en_p_i(ep), .en_t_i(et), .count_o(q), .tc_o(tc)
  );

  // three-stage chain
  logic        c_clr_n = 1'b1, c_ld_n = 1'b1, c_en = 1'b0;
  logic [11:0] c_d = 12'd0;
  logic [11:0] cq;
  logic [2:0]  ctc;
  logic [3:0]  c_et;
  int          ref_c = 0;
  assign c_et[0] = c_en;

  for (genvar s = 0; s < 3; s++) begin : g_chain
    presettable_counter u_stage (
      .clk_i(clk), .rst_ni(rst_n), .clr_ni(c_clr_n), .load_ni(c_ld_n),
      .data_i(c_d[4*s +: 4]), .en_p_i(c_en), .en_t_i(c_et[s]),
      .count_o(cq[4*s +: 4]), .tc_o(ctc[s])
    );
    assign c_et[s+1] = ctc[s];
  end

  // modulo-N stage with decoded clear
  logic [3:0] mq;
  logic       mtc;
  logic       m_clr_n;
  int         ref_m = 0;
  assign m_clr_n = (mq != 4'(MODN - 1));

  presettable_counter u_modn (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(m_clr_n), .load_ni(1'b1), .data_i(4'd0),
    .en_p_i(1'b1), .en_t_i(1'b1), .count_o(mq), .tc_o(mtc)
  );

  // behavioural reference models
  always @(posedge clk) begin
    if (!rst_n) ref_q = 0;
    else if (!clr_n) ref_q = 0;
    else if (!ld_n) ref_q = int'(d);
    else if (ep && et) ref_q = (ref_q + 1) % 16;

    if (!rst_n) ref_c = 0;
    else if (!c_clr_n) ref_c = 0;
    else if (!c_ld_n) ref_c = int'(c_d);
    else if (c_en) ref_c = (ref_c + 1) % 4096;

    if (!rst_n) ref_m = 0;
    else ref_m = (ref_m == MODN - 1) ? 0 : ref_m + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input int exp);
    n_chk++;
    if (act !== 32'(exp)) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one edge, then compare everything at the falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {28'd0, q}, ref_q);
    chk("R5 tc", {31'd0, tc}, (ref_q == 15 && et) ? 1 : 0);
    chk("R7 chain", {20'd0, cq}, ref_c);
    chk("R7 chain tc", {31'd0, ctc[2]}, (ref_c == 4095 && c_en) ? 1 : 0);
    chk("R8 modn", {28'd0, mq}, ref_m);
  endtask

  initial begin
    #20;
    chk("R6 reset", {28'd0, q}, 0);
    chk("R6 reset chain", {20'd0, cq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    c_en = 1'b1;

    // R3 count up through wrap
    ep = 1'b1; et = 1'b1;
    for (int i = 0; i < 18; i++) tick("R3 count");
    // R2 load with enables low
    ep = 1'b0; et = 1'b0; ld_n = 1'b0; d = 4'd13;
    tick("R2 load");
    ld_n = 1'b1;
    tick("R4 hold both low");
    // R1 clear beats load and enables
    clr_n = 1'b0; ld_n = 1'b0; d = 4'd7; ep = 1'b1; et = 1'b1;
    tick("R1 clear");
    clr_n = 1'b1;
    tick("R2 load priority");
    ld_n = 1'b1; d = 4'd15; ld_n = 1'b0;
    tick("R2 load max");
    ld_n = 1'b1;
    // R4/R5: at 15, only en_p low -> hold, tc still high
    ep = 1'b0; et = 1'b1;
    tick("R4 hold ep low");
    tick("R4 hold ep low again");
    // en_t low -> hold, tc low
    ep = 1'b1; et = 1'b0;
    tick("R4 hold et low");
    et = 1'b1;
    tick("R3 wrap from max");
    for (int i = 0; i < 5; i++) tick("R3 count");

    // R6 asynchronous reset mid-cycle
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk("R6 async", {28'd0, q}, 0);
    chk("R6 async chain", {20'd0, cq}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 chain across carry boundaries with mid-sequence load/clear
    c_ld_n = 1'b0; c_d = 12'h0FC;
    tick("R3 count");
    c_ld_n = 1'b1;
    for (int i = 0; i < 8; i++) tick("R7 carry 0xFF");
    c_en = 1'b0;
    for (int i = 0; i < 3; i++) tick("R7 chain hold");
    c_en = 1'b1; c_ld_n = 1'b0; c_d = 12'hFFB;
    tick("R7 chain load");
    c_ld_n = 1'b1;
    for (int i = 0; i < 9; i++) tick("R7 wrap 0xFFF");
    c_clr_n = 1'b0;
    tick("R7 chain clear");
    c_clr_n = 1'b1;
    for (int i = 0; i < 300; i++) tick("R7 free run");
    c_ld_n = 1'b0; c_d = 12'h7EF;
    tick("R7 load mid");
    c_ld_n = 1'b1;
    for (int i = 0; i < 20; i++) tick("R7 count on");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule